// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor built around a single accumulator. It works on 16-bit words in a 12-bit, word-addressed space held in an internal RAM. Each instruction is carried out as a fixed series of one-cycle register-transfer steps. A hardwired sequencer issues these steps. The programmer-visible state is the accumulator, the program counter, an instruction register, a memory address register, a memory buffer register, an input register and an output register.

A host fills the RAM through a load port while the core is held in reset, or after it has halted. It then releases reset, and execution starts at word 0. The core takes values from an input bus and reports results on an output bus with a one-cycle strobe. It raises a halted flag when it reaches the stop instruction. The instruction set includes a call that saves its return address in the first word of the subroutine, indirect load, store, add and jump, and a conditional skip whose test is chosen by two bits of the address field.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the core resets. After that edge `halted` and `out_valid` are 0 and `out_data` is 0. Once reset is released, the first instruction is fetched from word 0.
- R2: An instruction word holds the opcode in bits 15:12 and the operand address X in bits 11:0. Every instruction spends three fetch cycles, followed by a number of execute cycles set by its opcode: opcode 0 takes 7; opcodes 1, 3, 4 and C take 3; opcode 2 takes 2; opcodes B, D and E take 5; all others take 1. For a halting program, `halted` rises after exactly the sum of these cycles.
- R3: Opcode 1 loads AC from word X. Opcode 2 writes AC to word X. Opcode 3 adds word X to AC and opcode 4 subtracts it. The arithmetic is 16-bit two's complement and wraps.
- R4: Opcode 5 copies the input register into AC. The input register samples `in_data` on every clock. Opcode A clears AC to 0.
- R5: Opcode 6 places AC on `out_data` and raises `out_valid` for exactly one cycle. `out_data` changes at no other time.
- R6: Opcode 8 skips the next word when its condition holds. Bits 11:10 pick the condition: 00 means AC bit 15 is set, 01 means AC is zero, 10 means AC is nonzero with bit 15 clear, and 11 never skips.
- R7: Opcode 9 continues execution at X. Opcode C continues at the low 12 bits of word X.
- R8: Opcode 0 writes the address of the following instruction into word X, continues at X+1 and leaves AC equal to X+1.
- R9: Opcodes B, D and E read word X and use its low 12 bits as the data address. B adds that word to AC, D loads it into AC, and E writes AC into it.
- R10: Opcode 7 sets `halted`. After that the core fetches nothing and produces no output, and `halted` stays set until reset.
- R11: When `ld_en` is high at a rising edge, `ld_data` is written to word `ld_addr` only if `rst_n` is low or `halted` is high. At any other time the load port is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Program-load write strobe |
| ld_addr | input | 12 | Program-load word address |
| ld_data | input | 16 | Program-load word value |
| in_data | input | 16 | Input bus, sampled into the input register |
| out_data | output | 16 | Output register contents |
| out_valid | output | 1 | One-cycle strobe when the output register is written |
| halted | output | 1 | Core has executed the stop instruction |

## Verification
The bench checks the exact cycle at which `halted` rises, so a design that adds or drops a micro-step in any opcode's sequence fails the count. The skip test covers each condition code against a negative, a zero and a positive accumulator. A design that treats zero as positive, or that acts on code 11, then emits the wrong marker. The call test checks the return slot, the X+1 entry point and the accumulator left behind; a design that saved the address before the increment would return into a loop. Separate tests cover arithmetic wrap at 0x7FFF+1 and 0-1, pointer-based accesses, and load-port writes. A write attempted while the program runs must be ignored, and a write made while halted must land.

// File: rtl/acc_core_pkg.sv
// Package acc_core_pkg
// Shared opcodes, sequencer phases and the micro-step control word used
// across the accumulator core. Assumes a 4-bit opcode field.
package acc_core_pkg;

    localparam int OPC_W  = 4;
    localparam int STEP_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_CALL   = 4'h0,
        OP_LOAD   = 4'h1,
        OP_STORE  = 4'h2,
        OP_ADD    = 4'h3,
        OP_SUB    = 4'h4,
        OP_IN     = 4'h5,
        OP_OUT    = 4'h6,
        OP_STOP   = 4'h7,
        OP_SKIP   = 4'h8,
        OP_JMP    = 4'h9,
        OP_CLR    = 4'hA,
        OP_ADDP   = 4'hB,
        OP_JMPP   = 4'hC,
        OP_LOADP  = 4'hD,
        OP_STOREP = 4'hE,
        OP_SPARE  = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        PH_FETCH_A, PH_FETCH_B, PH_FETCH_C, PH_EXEC, PH_STOPPED
    } phase_e;

    typedef enum logic [1:0] {MAR_KEEP, MAR_FROM_PC, MAR_FROM_X, MAR_FROM_MBR} mar_src_e;
    typedef enum logic [2:0] {MBR_KEEP, MBR_FROM_MEM, MBR_FROM_AC, MBR_FROM_PC, MBR_FROM_X} mbr_src_e;
    typedef enum logic [2:0] {AC_KEEP, AC_FROM_MBR, AC_SUM, AC_DIFF, AC_FROM_IN, AC_ZERO, AC_ONE} ac_src_e;
    typedef enum logic [2:0] {PC_KEEP, PC_INC, PC_FROM_X, PC_FROM_MBR, PC_FROM_AC} pc_src_e;

    typedef struct packed {
        mar_src_e mar;
        mbr_src_e mbr;
        ac_src_e  ac;
        pc_src_e  pc;
        logic     mem_wr;
        logic     ir_ld;
        logic     out_ld;
        logic     last;
        logic     stop;
    } uop_t;

endpackage

// File: rtl/acc_word_ram.sv
// Module acc_word_ram
// Word-addressed RAM with one write port and one registered read port.
// A write to the address being read shows its new value on the read
// output in the next cycle. Contents are not reset.
module acc_word_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the write-port word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Register the read word, returning write data on an address match.
    always_ff @(posedge clk) begin
        if (we && (waddr == raddr)) begin
            rdata <= wdata;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/acc_alu.sv
// Module acc_alu
// Accumulator arithmetic (wrapping sum and difference) and the skip test.
// Condition code: 00 negative, 01 zero, 10 positive, 11 never.
module acc_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] ac,
    input  logic [DATA_W-1:0] mbr,
    input  logic [1:0]        cond,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] diff,
    output logic              cond_met
);
    logic is_neg;
    logic is_zero;

    assign sum     = ac + mbr;
    assign diff    = ac - mbr;
    assign is_neg  = ac[DATA_W-1];
    assign is_zero = (ac == '0);

    // Select the skip condition named by the two code bits.
    always_comb begin
        unique case (cond)
            2'b00:   cond_met = is_neg;
            2'b01:   cond_met = is_zero;
            2'b10:   cond_met = !is_neg && !is_zero;
            default: cond_met = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_sequencer.sv
// Module acc_sequencer
// Hardwired control: three fetch phases, then an execute phase that counts
// micro-steps for the current opcode, or a stopped phase that is left only
// by reset. Emits one control word per cycle. Assumes IR is stable in EXEC.
module acc_sequencer
    import acc_core_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             skip_hit,
    output uop_t             uop,
    output logic             halted
);
    phase_e            phase_q;
    logic [STEP_W-1:0] step_q;
    opcode_e           op;

    assign op     = opcode_e'(opcode);
    assign halted = (phase_q == PH_STOPPED);

    // Decode phase, opcode and step into the control word.
    always_comb begin
        uop = '0;
        unique case (phase_q)
            PH_FETCH_A: uop.mar = MAR_FROM_PC;
            PH_FETCH_B: begin uop.mbr = MBR_FROM_MEM; uop.pc = PC_INC; end
            PH_FETCH_C: uop.ir_ld = 1'b1;
            PH_EXEC: begin
                unique case (op)
                    OP_CALL: begin
                        case (step_q)
                            3'd0: uop.mbr = MBR_FROM_PC;
                            3'd1: uop.mar = MAR_FROM_X;
                            3'd2: uop.mem_wr = 1'b1;
                            3'd3: uop.mbr = MBR_FROM_X;
                            3'd4: uop.ac = AC_ONE;
                            3'd5: uop.ac = AC_SUM;
                            default: begin uop.pc = PC_FROM_AC; uop.last = 1'b1; end
                        endcase
                    end
                    OP_LOAD, OP_ADD, OP_SUB: begin
                        case (step_q)
                            3'd0: uop.mar = MAR_FROM_X;
                            3'd1: uop.mbr = MBR_FROM_MEM;
                            default: begin
                                uop.ac   = (op == OP_LOAD) ? AC_FROM_MBR :
                                           (op == OP_ADD)  ? AC_SUM : AC_DIFF;
                                uop.last = 1'b1;
                            end
                        endcase
                    end
                    OP_STORE: begin
                        if (step_q == 3'd0) begin
                            uop.mar = MAR_FROM_X;
                            uop.mbr = MBR_FROM_AC;
                        end else begin
                            uop.mem_wr = 1'b1;
                            uop.last   = 1'b1;
                        end
                    end
                    OP_ADDP, OP_LOADP, OP_STOREP, OP_JMPP: begin
                        case (step_q)
                            3'd0: uop.mar = MAR_FROM_X;
                            3'd1: uop.mbr = MBR_FROM_MEM;
                            3'd2: begin
                                if (op == OP_JMPP) begin
                                    uop.pc   = PC_FROM_MBR;
                                    uop.last = 1'b1;
                                end else begin
                                    uop.mar = MAR_FROM_MBR;
                                end
                            end
                            3'd3: uop.mbr = (op == OP_STOREP) ? MBR_FROM_AC : MBR_FROM_MEM;
                            default: begin
                                if (op == OP_STOREP) uop.mem_wr = 1'b1;
                                else if (op == OP_ADDP) uop.ac = AC_SUM;
                                else uop.ac = AC_FROM_MBR;
                                uop.last = 1'b1;
                            end
                        endcase
                    end
                    OP_IN:   begin uop.ac = AC_FROM_IN; uop.last = 1'b1; end
                    OP_OUT:  begin uop.out_ld = 1'b1; uop.last = 1'b1; end
                    OP_STOP: begin uop.stop = 1'b1; uop.last = 1'b1; end
                    OP_SKIP: begin uop.pc = skip_hit ? PC_INC : PC_KEEP; uop.last = 1'b1; end
                    OP_JMP:  begin uop.pc = PC_FROM_X; uop.last = 1'b1; end
                    OP_CLR:  begin uop.ac = AC_ZERO; uop.last = 1'b1; end
                    default: uop.last = 1'b1;
                endcase
            end
            default: uop = '0;
        endcase
    end

    // Advance the phase and the micro-step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH_A;
            step_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_FETCH_A: phase_q <= PH_FETCH_B;
                PH_FETCH_B: phase_q <= PH_FETCH_C;
                PH_FETCH_C: begin phase_q <= PH_EXEC; step_q <= '0; end
                PH_EXEC: begin
                    if (uop.stop)      phase_q <= PH_STOPPED;
                    else if (uop.last) phase_q <= PH_FETCH_A;
                    else               step_q  <= step_q + 1'b1;
                end
                default: phase_q <= PH_STOPPED;
            endcase
        end
    end

endmodule

// File: rtl/acc_core.sv
// Module acc_core
// Top of the accumulator processor: holds the architectural registers and
// ties the sequencer, ALU and RAM together. The RAM is read at the next
// MAR value, so its output always equals the word at MAR. The load port
// writes only while in reset or halted.
module acc_core #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              halted
);
    import acc_core_pkg::*;

    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] ac_q, ir_q, mbr_q, in_q, out_q;
    logic [ADDR_W-1:0] pc_q, mar_q;
    logic              out_vld_q;

    logic [DATA_W-1:0] ac_d, mbr_d, ram_q, alu_sum, alu_diff, ram_wdata;
    logic [ADDR_W-1:0] pc_d, mar_d, x_field, ram_raddr, ram_waddr;
    logic              skip_hit, core_we, load_ok, ram_we;
    uop_t              uop;

    assign x_field = ir_q[ADDR_W-1:0];

    acc_sequencer i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (ir_q[DATA_W-1 -: OPC_W]),
        .skip_hit (skip_hit),
        .uop      (uop),
        .halted   (halted)
    );

    acc_alu #(.DATA_W(DATA_W)) i_alu (
        .ac       (ac_q),
        .mbr      (mbr_q),
        .cond     (ir_q[ADDR_W-1 -: 2]),
        .sum      (alu_sum),
        .diff     (alu_diff),
        .cond_met (skip_hit)
    );

    // Memory write arbitration: core stores, otherwise gated host loads.
    assign core_we   = rst_n && uop.mem_wr;
    assign load_ok   = ld_en && (!rst_n || halted);
    assign ram_we    = core_we || load_ok;
    assign ram_waddr = core_we ? mar_q : ld_addr;
    assign ram_wdata = core_we ? mbr_q : ld_data;
    assign ram_raddr = rst_n ? mar_d : '0;

    acc_word_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_q)
    );

    // Next-value selection for each transfer register.
    always_comb begin
        unique case (uop.mar)
            MAR_FROM_PC:  mar_d = pc_q;
            MAR_FROM_X:   mar_d = x_field;
            MAR_FROM_MBR: mar_d = mbr_q[ADDR_W-1:0];
            default:      mar_d = mar_q;
        endcase
        unique case (uop.mbr)
            MBR_FROM_MEM: mbr_d = ram_q;
            MBR_FROM_AC:  mbr_d = ac_q;
            MBR_FROM_PC:  mbr_d = {{PAD_W{1'b0}}, pc_q};
            MBR_FROM_X:   mbr_d = {{PAD_W{1'b0}}, x_field};
            default:      mbr_d = mbr_q;
        endcase
        unique case (uop.ac)
            AC_FROM_MBR: ac_d = mbr_q;
            AC_SUM:      ac_d = alu_sum;
            AC_DIFF:     ac_d = alu_diff;
            AC_FROM_IN:  ac_d = in_q;
            AC_ZERO:     ac_d = '0;
            AC_ONE:      ac_d = {{(DATA_W-1){1'b0}}, 1'b1};
            default:     ac_d = ac_q;
        endcase
        unique case (uop.pc)
            PC_INC:      pc_d = pc_q + 1'b1;
            PC_FROM_X:   pc_d = x_field;
            PC_FROM_MBR: pc_d = mbr_q[ADDR_W-1:0];
            PC_FROM_AC:  pc_d = ac_q[ADDR_W-1:0];
            default:     pc_d = pc_q;
        endcase
    end

    // Architectural register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q      <= '0;
            pc_q      <= '0;
            ir_q      <= '0;
            mar_q     <= '0;
            mbr_q     <= '0;
            in_q      <= '0;
            out_q     <= '0;
            out_vld_q <= 1'b0;
        end else begin
            ac_q      <= ac_d;
            pc_q      <= pc_d;
            mar_q     <= mar_d;
            mbr_q     <= mbr_d;
            in_q      <= in_data;
            out_vld_q <= uop.out_ld;
            if (uop.ir_ld)  ir_q  <= mbr_q;
            if (uop.out_ld) out_q <= ac_q;
        end
    end

    assign out_data  = out_q;
    assign out_valid = out_vld_q;

endmodule

// File: rtl/acc_core_checker.sv
// Module acc_core_checker
// Temporal checks on the core's outputs and program counter, bound into
// every acc_core instance. Assumes synchronous active-low reset.
module acc_core_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [ADDR_W-1:0] pc
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!halted && !out_valid && out_data == '0 && pc == '0));

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> $stable(out_data));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (!out_valid && $stable(pc)));

endmodule

bind acc_core acc_core_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .halted    (halted),
    .out_valid (out_valid),
    .out_data  (out_data),
    .pc        (pc_q)
);

// File: tb/test_acc_core.sv
// Bench for acc_core: an instruction-level model predicts outputs and the
// cycle at which halted rises; random and directed programs are compared.
module test_acc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] in_data = '0;
    logic [15:0] out_data;
    logic        out_valid;
    logic        halted;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] mm [0:4095];
    logic [11:0] addr_list [0:511];
    int          n_list;
    logic [15:0] exp_out [0:255];
    int          n_exp;

    always #4 clk = ~clk;

    acc_core i_acc_core (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .in_data(in_data), .out_data(out_data),
        .out_valid(out_valid), .halted(halted)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 4096; i++) mm[i] = '0;
        n_list = 0;
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] d);
        mm[a] = d;
        addr_list[n_list] = a;
        n_list++;
    endtask

    // Instruction-level model following the requirements (R2..R10).
    task automatic model_run(input logic [15:0] inval, output int cyc);
        logic [11:0] pc, x, ea;
        logic [15:0] ac, w;
        bit done, hit;
        pc = '0; ac = '0; cyc = 0; n_exp = 0; done = 0;
        for (int g = 0; g < 5000 && !done; g++) begin
            w = mm[pc]; pc = pc + 12'd1; x = w[11:0]; cyc += 3;
            ea = mm[x][11:0];
            case (w[15:12])
                4'h0: begin mm[x] = {4'h0, pc}; ac = {4'h0, x} + 16'd1; pc = x + 12'd1; cyc += 7; end
                4'h1: begin ac = mm[x]; cyc += 3; end
                4'h2: begin mm[x] = ac; cyc += 2; end
                4'h3: begin ac = ac + mm[x]; cyc += 3; end
                4'h4: begin ac = ac - mm[x]; cyc += 3; end
                4'h5: begin ac = inval; cyc += 1; end
                4'h6: begin if (n_exp < 256) exp_out[n_exp] = ac; n_exp++; cyc += 1; end
                4'h7: begin done = 1; cyc += 1; end
                4'h8: begin
                    case (w[11:10])
                        2'b00:   hit = ac[15];
                        2'b01:   hit = (ac == 16'h0);
                        2'b10:   hit = !ac[15] && (ac != 16'h0);
                        default: hit = 0;
                    endcase
                    if (hit) pc = pc + 12'd1;
                    cyc += 1;
                end
                4'h9: begin pc = x; cyc += 1; end
                4'hA: begin ac = '0; cyc += 1; end
                4'hB: begin ac = ac + mm[ea]; cyc += 5; end
                4'hC: begin pc = ea; cyc += 3; end
                4'hD: begin ac = mm[ea]; cyc += 5; end
                4'hE: begin mm[ea] = ac; cyc += 5; end
                default: cyc += 1;
            endcase
        end
    endtask

    // Load, reset, run to halt and compare outputs and timing.
    task automatic run_prog(input string tag, input logic [15:0] inval,
                            input bit try_ld, input logic [11:0] ign_a, input logic [15:0] ign_d);
        int exp_cyc, cyc, n_cap;
        bit quiet;
        logic [15:0] cap [0:255];
        @(negedge clk);
        rst_n = 1'b0;
        in_data = inval;
        for (int i = 0; i < n_list; i++) begin
            ld_en = 1'b1; ld_addr = addr_list[i]; ld_data = mm[addr_list[i]];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        check(!halted && !out_valid && out_data == 16'h0, "R1 reset state",
              {14'h0, halted, out_valid, out_data}, 32'h0);
        model_run(inval, exp_cyc);
        rst_n = 1'b1; cyc = 0; n_cap = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (try_ld) begin
                if (cyc == 2) begin ld_en = 1'b1; ld_addr = ign_a; ld_data = ign_d; end
                else ld_en = 1'b0;
            end
            if (out_valid) begin
                if (n_cap < 256) cap[n_cap] = out_data;
                n_cap++;
            end
            if (halted) break;
        end
        check(halted == 1'b1, "R10 halted reached", {31'h0, halted}, 32'h1);
        check(cyc == exp_cyc, "R2 cycles to halt", cyc, exp_cyc);
        check(n_cap == n_exp, {tag, " output count"}, n_cap, n_exp);
        for (int i = 0; i < n_exp && i < n_cap && i < 256; i++)
            check(cap[i] == exp_out[i], {tag, " output value"}, {16'h0, cap[i]}, {16'h0, exp_out[i]});
        quiet = 1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (out_valid || !halted) quiet = 0;
        end
        check(quiet, "R10 quiet after halt", {31'h0, quiet}, 32'h1);
    endtask

    function automatic logic [15:0] pick_data();
        case ($urandom % 8)
            0: return 16'h0000;
            1: return 16'h8000;
            2: return 16'h7FFF;
            3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic gen_random(input int len);
        logic [11:0] d, p;
        logic [15:0] w;
        int k;
        clear_prog();
        for (int i = 0; i < 16; i++) put(12'h800 + 12'(i), pick_data());
        for (int i = 0; i < 8; i++) put(12'h810 + 12'(i), 16'h0800 + 16'($urandom % 16));
        for (int i = 0; i < len; i++) begin
            d = 12'h800 + 12'($urandom % 16);
            p = 12'h810 + 12'($urandom % 8);
            case ($urandom % 11)
                0: w = ins(4'h1, d);
                1: w = ins(4'h2, d);
                2: w = ins(4'h3, d);
                3: w = ins(4'h4, d);
                4: w = ins(4'h5, 12'h0);
                5: w = ins(4'h6, 12'h0);
                6: w = {4'h8, 2'($urandom % 4), 10'h0};
                7: w = ins(4'hA, 12'h0);
                8: w = ins(4'hB, p);
                9: w = ins(4'hD, p);
                default: w = ins(4'hE, p);
            endcase
            put(12'(i), w);
        end
        k = len;
        for (int i = 0; i < 4; i++) begin
            put(12'(k), ins(4'h1, 12'h800 + 12'(i))); k++;
            put(12'(k), ins(4'h6, 12'h0)); k++;
        end
        put(12'(k), ins(4'h7, 12'h0));
    endtask

    task automatic run_all();
        int p;
        // R3 R4: wrap on add and subtract, input copy, store and reload.
        clear_prog();
        put(12'h800, 16'h7FFF); put(12'h801, 16'h0001);
        put(0, ins(1, 12'h800)); put(1, ins(3, 12'h801)); put(2, ins(6, 0));
        put(3, ins(4'hA, 0)); put(4, ins(4, 12'h801)); put(5, ins(6, 0));
        put(6, ins(5, 0)); put(7, ins(6, 0)); put(8, ins(2, 12'h805));
        put(9, ins(4'hA, 0)); put(10, ins(1, 12'h805)); put(11, ins(6, 0));
        put(12, ins(7, 0));
        run_prog("R3 R4 arithmetic", 16'hBEEF, 0, 12'h0, 16'h0);

        // R6: every condition code against negative, zero and positive AC.
        clear_prog();
        put(12'h800, 16'h8000); put(12'h801, 16'h0000); put(12'h802, 16'h0005);
        put(12'h803, 16'h1234);
        p = 0;
        for (int v = 0; v < 3; v++) begin
            for (int c = 0; c < 4; c++) begin
                put(12'(p), ins(1, 12'h800 + 12'(v))); p++;
                put(12'(p), {4'h8, 2'(c), 10'h0}); p++;
                put(12'(p), ins(1, 12'h803)); p++;
                put(12'(p), ins(6, 0)); p++;
            end
        end
        put(12'(p), ins(7, 0));
        run_prog("R6 skip", 16'h0, 0, 12'h0, 16'h0);

        // R8 R7 R11: call and return, direct jump, ignored load while running.
        clear_prog();
        put(0, ins(0, 12'h100)); put(1, ins(6, 0)); put(2, ins(9, 12'h004));
        put(3, ins(6, 0)); put(4, ins(1, 12'h100)); put(5, ins(6, 0));
        put(6, ins(4'hC, 12'h120)); put(7, ins(6, 0)); put(8, ins(7, 0));
        put(12'h100, 16'h0); put(12'h101, ins(6, 0)); put(12'h102, ins(4'hC, 12'h100));
        put(12'h120, 16'h0008);
        run_prog("R8 R7 R11 call", 16'h0, 1, 12'h120, 16'h0003);

        // R9 R7: pointer-based load, add, store and jump.
        clear_prog();
        put(12'h810, 16'h0803); put(12'h803, 16'h0042);
        put(12'h811, 16'h0806); put(12'h806, 16'h0000); put(12'h812, 16'h000A);
        put(0, ins(4'hD, 12'h810)); put(1, ins(6, 0)); put(2, ins(4'hB, 12'h810));
        put(3, ins(6, 0)); put(4, ins(4'hE, 12'h811)); put(5, ins(1, 12'h806));
        put(6, ins(6, 0)); put(7, ins(4'hC, 12'h812)); put(8, ins(6, 0));
        put(9, ins(7, 0)); put(10, ins(4'hA, 0)); put(11, ins(6, 0)); put(12, ins(7, 0));
        run_prog("R9 R7 indirect", 16'h0, 0, 12'h0, 16'h0);

        // R11: a load made while halted lands in memory.
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 12'h900; ld_data = 16'hA5C3;
        @(negedge clk);
        ld_en = 1'b0;
        clear_prog();
        put(0, ins(1, 12'h900)); put(1, ins(6, 0)); put(2, ins(7, 0));
        mm[12'h900] = 16'hA5C3;
        run_prog("R11 halted load", 16'h0, 0, 12'h0, 16'h0);

        // R3 R4 R5 R6 R9: constrained random straight-line programs.
        for (int r = 0; r < 25; r++) begin
            gen_random(20 + int'($urandom % 21));
            run_prog("R3 R5 R9 random", 16'($urandom), 0, 12'h0, 16'h0);
        end
    endtask

    initial begin
        bit wd_hit;
        wd_hit = 0;
        void'($urandom(32'h5EED));
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        disable fork;
        if (wd_hit) check(0, "R10 watchdog expired", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule